// File: doc/BRIEF.md
# Synchronous Linear Burst Read Controller

This block is the device-side read control for a memory with a 32-bit data path and a synchronous burst port. Chip enable, address valid, output enable and reset are all sampled on the rising clock. When a burst is requested, the block captures a start address and waits a configurable initial latency. It then returns one double word per clock from consecutive addresses. A small stand-in array supplies the data.

The data bus and a one-clock, active-low end-of-burst indicator are each given as a value output plus a drive enable. Output enable only switches the drivers. The burst keeps counting inside the block whether or not data is driven.

A six-bit configuration register is written through a dedicated port. It selects burst operation, the burst length, the latency, and whether the indicator marks the final word or the word before it. The settings are captured when each burst starts.

Top module: `lburst_rd`

## Requirements
- R1: After reset the configuration register is all zeros. Bit 0 = 0 means non-burst mode: no burst starts, and neither driver is enabled.
- R2: Configuration bit 0 enables bursts. Bits 2:1 set the length: 0 gives 2 words, 1 gives 4, and 2 or 3 give 8. Bits 4:3 set the latency L = code + 2 clocks. Bit 5 = 1 moves the indicator to the second-to-last word.
- R3: A rising edge that samples ce_n = 0, adv_n = 0 and burst mode captures addr. Word k of the burst (k from 0) is presented after edge start + L + k.
- R4: A burst presents exactly N words, at addresses base, base+1, and so on, with no wrap inside any aligned block. The word for address a is {a[15:0] ^ 16'hC3A5, a[15:0]}.
- R5: An edge that samples ce_n = 1 ends the burst. After that edge both drivers are off. No further word of that burst appears, even if ce_n returns low.
- R6: An edge that samples adv_n = 0 during a burst discards it and restarts from the new address. No word is presented while adv_n stays low.
- R7: While oe_n is sampled high, both drivers are off after that edge. The address and word count keep advancing, so words skipped this way never reappear.
- R8: eob_n goes low for exactly one clock. That clock is word N-1 when bit 5 is 0, and word N-2 when bit 5 is 1.
- R9: The indicator is driven exactly when the data bus is driven, and it is high on every driven word except the marked one.
- R10: A reset edge stops any burst, turns both drivers off, and clears the configuration register.
- R11: A configuration write during a burst does not change that burst. The new settings apply from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Burst start address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write value |
| dq | output | 32 | Data value |
| dq_oe | output | 1 | Data bus drive enable |
| eob_n | output | 1 | End-of-burst indicator value, active low |
| eob_oe | output | 1 | Indicator drive enable |

## Verification
The hardest case to reach is a burst whose words go undriven for a while and then resume at the right later address. To reach it, output enable must be raised in the middle of the data phase and lowered before the burst ends, so the invisible counter advance shows up in the returned value. Restarts that land inside the latency window are similarly hard, as are configuration writes made while a burst is running. Directed sequences force each of these cases once. A long random run then mixes sparse address-valid pulses, enable toggles, configuration writes and occasional resets, and a cycle-accurate model in the bench scores every cycle.

// File: rtl/lburst_rd.sv
module lburst_rd #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_wdata,
  output logic [31:0]   dq,
  output logic          dq_oe,
  output logic          eob_n,
  output logic          eob_oe
);
  localparam int CW = 6;
  localparam int NW = 4;

  logic [CW-1:0] cfg_q;
  logic          active, early_q, drv_q, eob_q;
  logic [2:0]    lat_q;
  logic [NW-1:0] left_q, len_w;
  logic [AW-1:0] ptr_q;
  logic [31:0]   dq_q;

  function automatic logic [31:0] word_at(input logic [AW-1:0] a);
    logic [31:0] ax;
    ax = 32'(a);
    return {ax[15:0] ^ 16'hC3A5, ax[15:0]};
  endfunction

  always_comb begin
    case (cfg_q[2:1])
      2'd0:    len_w = NW'(2);
      2'd1:    len_w = NW'(4);
      default: len_w = NW'(8);
    endcase
  end

  wire [2:0] lat_w   = 3'(cfg_q[4:3]) + 3'd1;
  wire       start   = !ce_n && !adv_n && cfg_q[0];
  wire       launch  = !ce_n && !start && active && (lat_q == 3'd0);
  wire       last    = (left_q == NW'(1));
  wire       eob_hit = early_q ? (left_q == NW'(2)) : last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      active  <= 1'b0;
      early_q <= 1'b0;
      drv_q   <= 1'b0;
      eob_q   <= 1'b0;
      lat_q   <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      dq_q    <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      drv_q <= launch && !oe_n;
      eob_q <= launch && eob_hit;
      if (launch) begin
        dq_q   <= word_at(ptr_q);
        ptr_q  <= ptr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
      if (ce_n) begin
        active <= 1'b0;
      end else if (start) begin
        active  <= 1'b1;
        ptr_q   <= addr;
        left_q  <= len_w;
        lat_q   <= lat_w;
        early_q <= cfg_q[5];
      end else if (active) begin
        if (lat_q != 3'd0) lat_q <= lat_q - 1'b1;
        else if (last)     active <= 1'b0;
      end
    end
  end

  assign dq     = dq_q;
  assign dq_oe  = drv_q;
  assign eob_oe = drv_q;
  assign eob_n  = !eob_q;

  AST_CE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dq_oe && !eob_oe)); // R5
  AST_EOB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eob_n |=> eob_n); // R8
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !dq_oe); // R7
  AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && !active) |=> !dq_oe); // R1
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q != '0)); // R4
  AST_RESET_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!dq_oe && eob_n)); // R10
endmodule

// File: tb/test_lburst_rd.sv
`timescale 1ns/1ps
module test_lburst_rd;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [5:0]    cfg_wdata = '0;
  logic [31:0]   dq;
  logic          dq_oe, eob_n, eob_oe;

  lburst_rd #(.AW(AW)) i_lburst_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr(addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dq(dq), .dq_oe(dq_oe), .eob_n(eob_n), .eob_oe(eob_oe)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R10";

  logic [5:0]    m_cfg = '0;
  bit            m_alive = 0, m_early = 0;
  int            m_sc = 0, m_n = 0, m_L = 0, cyc = 0;
  logic [AW-1:0] m_base = '0;
  bit            e_oe = 0, e_eob_n = 1;
  logic [31:0]   e_dq = '0;

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    logic [31:0] x = 32'(a);
    return {x[15:0] ^ 16'hC3A5, x[15:0]};
  endfunction

  function automatic int len_of(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 4 : 8;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    int  k;
    bit  go;
    @(posedge clk);
    go = 0;
    if (!rst_n) begin
      m_cfg = '0; m_alive = 0;
    end else begin
      if (ce_n) m_alive = 0;
      else if (!adv_n && m_cfg[0]) begin
        m_alive = 1; m_sc = cyc; m_base = addr;
        m_n = len_of(m_cfg[2:1]); m_L = int'(m_cfg[4:3]) + 2; m_early = m_cfg[5];
      end else if (m_alive) begin
        k = cyc - m_sc - m_L;
        if (k >= 0) begin
          go = 1;
          e_dq = pat(m_base + AW'(k));
          e_eob_n = !(m_early ? (k == m_n - 2) : (k == m_n - 1));
          if (k == m_n - 1) m_alive = 0;
        end
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
    e_oe = go && rst_n && !oe_n;
    if (!go || !rst_n) e_eob_n = 1;
    cyc++;
    @(negedge clk);
    check("dq_oe", 32'(dq_oe), 32'(e_oe));
    check("eob_oe", 32'(eob_oe), 32'(e_oe));
    check("eob_n", 32'(eob_n), 32'(e_eob_n));
    if (e_oe) check("dq", dq, e_dq);
  endtask

  task automatic wcfg(input logic [5:0] v);
    cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
  endtask

  task automatic begin_burst(input logic [AW-1:0] a);
    ce_n = 0; adv_n = 0; addr = a; step(); adv_n = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #750000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    tag = "R10"; idle(2);
    rst_n = 1;
    tag = "R1"; begin_burst(19'h00100); idle(12); ce_n = 1; step();
    // length 4, latency 2, late indicator; crosses a 4K boundary
    tag = "R3"; wcfg(6'b0_00_01_1);
    tag = "R4"; begin_burst(19'h00FFE); idle(8);
    tag = "R2"; wcfg(6'b1_11_10_1);
    tag = "R8"; begin_burst(19'h12340); idle(16);
    wcfg(6'b0_00_00_1); begin_burst(19'h00050); idle(5);
    wcfg(6'b1_00_00_1); begin_burst(19'h00060); idle(5);
    tag = "R5"; wcfg(6'b0_01_10_1); begin_burst(19'h00200); idle(5);
    ce_n = 1; step(); ce_n = 0; idle(8);
    tag = "R6"; begin_burst(19'h00300); idle(3);
    ce_n = 0; adv_n = 0; addr = 19'h00400; step(); step(); adv_n = 1; idle(10);
    tag = "R7"; begin_burst(19'h00500); idle(4);
    oe_n = 1; idle(2); oe_n = 0; idle(6);
    tag = "R11"; begin_burst(19'h00600); wcfg(6'b1_00_11_1); idle(10);
    begin_burst(19'h00700); idle(10);
    tag = "R10"; begin_burst(19'h00800); idle(6);
    rst_n = 0; step(); rst_n = 1; step();
    tag = "R1"; begin_burst(19'h00900); idle(10);
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      ce_n  = ($urandom_range(0, 15) == 0);
      adv_n = ($urandom_range(0, 9) != 0);
      oe_n  = ($urandom_range(0, 5) == 0);
      addr  = AW'($urandom);
      rst_n = ($urandom_range(0, 499) != 0);
      cfg_we = ($urandom_range(0, 19) == 0);
      cfg_wdata = 6'($urandom) | 6'd1;
      step();
    end
    cfg_we = 0; rst_n = 1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule